// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two independent count channels. Each channel is built from a low count byte and a high count byte. A shared mode byte sets up both channels, and a shared control/status byte holds the run bits, the overflow flags and four bits of plain storage. Each channel can run in one of four arrangements: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, or a split arrangement in which channel 0 becomes two separate 8-bit counters. A channel counts either a tick taken once every 12 system clocks or falling edges on its external count pin. An external level input can gate its counting.

A host reaches the six registers through a plain synchronous port: `wr_en`, a 3-bit address and a data byte. Reads are combinational from the address, so there is no data stream and no back-pressure. The two overflow flags are also driven out on pins.

Register addresses: 0 = control/status, 1 = mode, 2 = channel 0 low, 3 = channel 0 high, 4 = channel 1 low, 5 = channel 1 high. Addresses 6 and 7 read as 0 and ignore writes.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset, all six registers read 0, both flags are 0, and no channel counts.
- R2: Mode byte: bits 3:0 configure channel 0 and bits 7:4 configure channel 1. Within each nibble, bit 0 = M0, bit 1 = M1, bit 2 = count source (1 = external pin), and bit 3 = gate enable. Control byte: bit 4 = run 0, bit 5 = flag 0, bit 6 = run 1, bit 7 = flag 1, and bits 3:0 are storage. Every register reads back what was last written to it.
- R3: With count source 0 and the run bit set, a channel advances once every 12 system clocks. A stopped channel holds its count.
- R4: In mode 1 (M1M0 = 01), the high and low bytes form a 16-bit up-counter. The step from FFFF to 0000 sets the channel's flag, and counting goes on.
- R5: In mode 0 (00), the count is {high byte, low byte bits 4:0}, 13 bits in all. Low byte bits 7:5 never change by counting. The wrap from all ones sets the flag.
- R6: In mode 2 (10), only the low byte counts. A step taken from FF sets the flag and loads the low byte with the high byte.
- R7: In mode 3 (11), channel 0's low byte is an 8-bit counter under channel 0's controls and sets flag 0. Channel 0's high byte counts internal ticks while run 1 is set, and its wrap sets flag 1. While channel 0 is in mode 3, channel 1's overflow never sets flag 1. Channel 1 in mode 3 holds its count.
- R8: With count source 1, the channel counts each falling edge of its count pin after a two-flop synchronizer, at most once per edge.
- R9: With gate enable 1, a channel counts only while its run bit is 1 and its synchronized gate pin is high.
- R10: A register write wins over hardware in the same cycle. A write to either count byte of a channel suppresses that channel's step. The exception is mode 3 on channel 0, where each byte blocks only its own counter. A write to the control byte overrides any flag set in that cycle.
- R11: The flags are sticky until software writes the control byte. `ovf_flag[0]` and `ovf_flag[1]` mirror control bits 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register at `addr` (combinational) |
| cnt_in | input | 2 | External count pins, one per channel |
| gate_in | input | 2 | External gate pins, one per channel |
| ovf_flag | output | 2 | Overflow flags (bit 1 = flag 1, bit 0 = flag 0) |

## Verification
The assertions check the following on every cycle:
- a reload loads the low byte from the high byte;
- low bits 7:5 stay frozen in mode 0;
- a written byte lands as written;
- prescaler ticks and detected edges never come on consecutive cycles;
- flags stay sticky;
- a stopped channel holds its count;
- channel 1 in split mode holds, and its overflow stays away from flag 1.

Only the bench scenarios can show the following:
- the exact 12-clock count rate and the synchronizer latency;
- the 13-bit and 16-bit wrap points;
- gate-window measurement;
- the cycle where a write collides with a count edge.

The bench shows these by comparing a behavioural model against the outputs on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } cnt_mode_e;

  // nibble layout: gate, source, mode[1:0]
  typedef struct packed {
    logic      gate;
    logic      ext_sel;
    cnt_mode_e mode;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R3: ticks are spaced, never back to back
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_pin,
  input  logic gate_pin,
  output logic cnt_fall,
  output logic gate_lvl
);
  logic [STAGES-1:0] cnt_sq;
  logic [STAGES-1:0] gate_sq;
  logic              cnt_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_sq   <= '0;
      gate_sq  <= '0;
      cnt_prev <= 1'b0;
    end else begin
      cnt_sq   <= {cnt_sq[STAGES-2:0], cnt_pin};
      gate_sq  <= {gate_sq[STAGES-2:0], gate_pin};
      cnt_prev <= cnt_sq[STAGES-1];
    end
  end

  assign cnt_fall = cnt_prev & ~cnt_sq[STAGES-1];
  assign gate_lvl = gate_sq[STAGES-1];

  // R8: one edge gives one count pulse
  assert_single_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fall |=> !cnt_fall);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W         = BYTE_W,
  parameter int PRE_W     = 5,
  parameter bit CAN_SPLIT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_mode_e    mode,
  input  logic         inc_main,
  input  logic         inc_split,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf_main,
  output logic         ovf_split
);
  logic [W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic         split_md, step_m, step_s;
  logic         ovf_m, ovf_s;

  assign split_md = (mode == MODE_SPLIT);
  assign step_m   = inc_main & ~wr_lo & ~(wr_hi & ~split_md);
  assign step_s   = inc_split & ~wr_hi;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    ovf_m = 1'b0;
    ovf_s = 1'b0;
    case (mode)
      MODE_13: if (step_m) begin
        if (&lo_q[PRE_W-1:0]) begin
          lo_d[PRE_W-1:0] = '0;
          hi_d            = hi_q + 1'b1;
          ovf_m           = &hi_q;
        end else begin
          lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
        end
      end
      MODE_16: if (step_m) begin
        {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
        ovf_m        = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (step_m) begin
        if (&lo_q) begin
          lo_d  = hi_q;
          ovf_m = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end
      MODE_SPLIT: if (CAN_SPLIT) begin
        if (step_m) begin
          lo_d  = lo_q + 1'b1;
          ovf_m = &lo_q;
        end
        if (step_s) begin
          hi_d  = hi_q + 1'b1;
          ovf_s = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo        = lo_q;
  assign hi        = hi_q;
  assign ovf_main  = ovf_m;
  assign ovf_split = ovf_s;

  // R6: a reload overflow copies the high byte into the low byte
  assert_reload_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RELOAD && ovf_main) |=> (lo_q == $past(hi_q)));

  // R5: top three low bits are frozen in 13-bit mode
  assert_mode0_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_13 && !wr_lo) |=> (lo_q[W-1:PRE_W] == $past(lo_q[W-1:PRE_W])));

  // R10: a write lands exactly as written
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));

  generate
    if (!CAN_SPLIT) begin : g_hold
      // R7: a channel that cannot split holds in mode 3
      assert_split_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (split_md && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
    end
  endgenerate
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import tmr_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [NUM_CH-1:0] cnt_in,
  input  logic [NUM_CH-1:0] gate_in,
  output logic [NUM_CH-1:0] ovf_flag
);
  localparam int RUN0_B = 4;
  localparam int FLG0_B = 5;
  localparam int RUN1_B = 6;
  localparam int FLG1_B = 7;

  logic [BYTE_W-1:0] ctrl_q, mode_q;
  logic              tick, wr_ctrl, wr_mode;
  logic              set_f0, set_f1;
  chan_cfg_t         cfg      [NUM_CH];
  logic [NUM_CH-1:0] run, fall, gate_lvl, inc, ovf_m, ovf_s, wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo_v     [NUM_CH];
  logic [BYTE_W-1:0] hi_v     [NUM_CH];

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_mode = wr_en && (addr == A_MODE);
  assign run[0]  = ctrl_q[RUN0_B];
  assign run[1]  = ctrl_q[RUN1_B];
  assign cfg[0]  = chan_cfg_t'(mode_q[3:0]);
  assign cfg[1]  = chan_cfg_t'(mode_q[7:4]);

  tmr_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cnt_pin(cnt_in[c]), .gate_pin(gate_in[c]),
        .cnt_fall(fall[c]), .gate_lvl(gate_lvl[c])
      );

      assign inc[c]   = run[c] & (~cfg[c].gate | gate_lvl[c])
                        & (cfg[c].ext_sel ? fall[c] : tick);
      assign wr_lo[c] = wr_en && (addr == ADDR_W'(2 + 2 * c));
      assign wr_hi[c] = wr_en && (addr == ADDR_W'(3 + 2 * c));

      tmr_channel #(.W(BYTE_W), .PRE_W(5), .CAN_SPLIT(c == 0)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .mode(cfg[c].mode),
        .inc_main(inc[c]),
        .inc_split((c == 0) ? (run[1] & tick) : 1'b0),
        .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]), .wdata(wdata),
        .lo(lo_v[c]), .hi(hi_v[c]),
        .ovf_main(ovf_m[c]), .ovf_split(ovf_s[c])
      );
    end
  endgenerate

  assign set_f0 = ovf_m[0];
  assign set_f1 = (cfg[0].mode == MODE_SPLIT) ? ovf_s[0] : ovf_m[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
      else begin
        if (set_f0) ctrl_q[FLG0_B] <= 1'b1;
        if (set_f1) ctrl_q[FLG1_B] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_MODE:  rdata = mode_q;
      A_LO0:   rdata = lo_v[0];
      A_HI0:   rdata = hi_v[0];
      A_LO1:   rdata = lo_v[1];
      A_HI1:   rdata = hi_v[1];
      default: rdata = '0;
    endcase
  end

  assign ovf_flag = {ctrl_q[FLG1_B], ctrl_q[FLG0_B]};

  // R11: flags stay set until the control byte is written
  assert_flag0_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[FLG0_B] && !wr_ctrl) |=> ctrl_q[FLG0_B]);
  assert_flag1_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[FLG1_B] && !wr_ctrl) |=> ctrl_q[FLG1_B]);

  // R3: with both runs clear and no write, channel 0 holds
  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !run[1] && !wr_lo[0] && !wr_hi[0])
      |=> ($stable(lo_v[0]) && $stable(hi_v[0])));

  // R7: channel 1 overflow cannot raise flag 1 while channel 0 is split
  assert_split_flag1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0].mode == MODE_SPLIT && ovf_m[1] && !ovf_s[0] && !wr_ctrl
     && !ctrl_q[FLG1_B]) |=> !ctrl_q[FLG1_B]);
endmodule

// File: tb/dual_timer_counter_tb_top.sv
module dual_timer_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] cnt_in = 2'b11;
  logic [1:0] gate_in = 2'b00;
  logic [1:0] ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  dual_timer_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_in(cnt_in), .gate_in(gate_in), .ovf_flag(ovf_flag)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  int m_ctrl, m_mode, pc;
  int m_lo[2], m_hi[2], s1[2], s2[2], pv[2], g1[2], g2[2];

  function automatic logic [16:0] adv(int md, int lo, int hi);
    int v; bit o;
    o = 0;
    if (md == 0) begin
      v = hi * 32 + (lo % 32) + 1;
      o = (v == 8192); v = v % 8192;
      hi = v / 32; lo = (lo / 32) * 32 + (v % 32);
    end else if (md == 1) begin
      v = hi * 256 + lo + 1;
      o = (v == 65536); v = v % 65536;
      hi = v / 256; lo = v % 256;
    end else if (md == 2) begin
      if (lo == 255) begin lo = hi; o = 1; end else lo = lo + 1;
    end
    return {o, hi[7:0], lo[7:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_mode = 0; pc = 0;
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = 0; m_hi[c] = 0; s1[c] = 0; s2[c] = 0; pv[c] = 0; g1[c] = 0; g2[c] = 0;
      end
    end else begin
      bit tck; bit pulse[2]; int md[2]; bit wl[2]; bit wh[2];
      bit o0, o1, os; logic [16:0] r;
      tck = (pc == 11);
      for (int c = 0; c < 2; c++) begin
        int nib; bit rn, en;
        nib = (m_mode >> (4 * c)) % 16;
        md[c] = nib % 4;
        rn = ((m_ctrl >> (4 + 2 * c)) % 2) == 1;
        en = rn && ((nib / 8) == 0 || g2[c] == 1);
        pulse[c] = en && (((nib / 4) % 2 == 1) ? (pv[c] == 1 && s2[c] == 0) : tck);
        wl[c] = wr_en && (addr == 3'(2 + 2 * c));
        wh[c] = wr_en && (addr == 3'(3 + 2 * c));
      end
      o0 = 0; o1 = 0; os = 0;
      if (md[0] == 3) begin
        if (pulse[0] && !wl[0]) begin
          if (m_lo[0] == 255) begin m_lo[0] = 0; o0 = 1; end else m_lo[0]++;
        end
        if (((m_ctrl >> 6) % 2 == 1) && tck && !wh[0]) begin
          if (m_hi[0] == 255) begin m_hi[0] = 0; os = 1; end else m_hi[0]++;
        end
      end else if (pulse[0] && !wl[0] && !wh[0]) begin
        r = adv(md[0], m_lo[0], m_hi[0]);
        o0 = r[16]; m_hi[0] = r[15:8]; m_lo[0] = r[7:0];
      end
      if (md[1] != 3 && pulse[1] && !wl[1] && !wh[1]) begin
        r = adv(md[1], m_lo[1], m_hi[1]);
        o1 = r[16]; m_hi[1] = r[15:8]; m_lo[1] = r[7:0];
      end
      for (int c = 0; c < 2; c++) begin
        if (wl[c]) m_lo[c] = wdata;
        if (wh[c]) m_hi[c] = wdata;
      end
      if (wr_en && addr == 3'd1) m_mode = wdata;
      if (wr_en && addr == 3'd0) m_ctrl = wdata;
      else begin
        if (o0) m_ctrl = m_ctrl | 32;
        if ((md[0] == 3) ? os : o1) m_ctrl = m_ctrl | 128;
      end
      for (int c = 0; c < 2; c++) begin
        pv[c] = s2[c]; s2[c] = s1[c]; s1[c] = cnt_in[c];
        g2[c] = g1[c]; g1[c] = gate_in[c];
      end
      pc = (pc == 11) ? 0 : pc + 1;
    end
  end

  function automatic int exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_mode;
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(cur_req, int'(ovf_flag), ((m_ctrl >> 7) % 2) * 2 + (m_ctrl >> 5) % 2, "ovf_flag");
      chk(cur_req, int'(rdata), exp_rd(addr), $sformatf("rdata@%0d", addr));
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); addr = 3'(i % 6);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    cur_req = "R1";
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); chk("R1", v, 0, "reset reg"); end
    chk("R1", int'(ovf_flag), 0, "reset flags");
    idle(30);
    rd(3'd3, v); chk("R1", v, 0, "no count after reset");

    // R2: register layout and readback; R11 output mirror
    cur_req = "R2";
    wr(3'd1, 8'hA5); rd(3'd1, v); chk("R2", v, 8'hA5, "mode readback");
    wr(3'd0, 8'h0A); rd(3'd0, v); chk("R2", v, 8'h0A, "ctrl storage bits");
    wr(3'd0, 8'hA0); #1; chk("R11", int'(ovf_flag), 3, "flags mirror bits 7,5");
    wr(3'd0, 8'h00); #1; chk("R11", int'(ovf_flag), 0, "flags cleared by write");

    // R3/R4: 16-bit wrap on internal ticks
    cur_req = "R4";
    wr(3'd1, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    idle(60);
    rd(3'd3, v); chk("R4", v, 0, "hi after 16-bit wrap");
    chk("R4", int'(ovf_flag[0]), 1, "flag0 on 16-bit wrap");
    rd(3'd2, v); chk("R3", int'(v >= 2 && v <= 4), 1, "tick rate about 1/12");
    idle(40); chk("R11", int'(ovf_flag[0]), 1, "flag0 sticky");

    // R5: 13-bit mode on channel 1
    cur_req = "R5";
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF); wr(3'd0, 8'h40);
    idle(60);
    rd(3'd5, v); chk("R5", v, 0, "hi after 13-bit wrap");
    rd(3'd4, v); chk("R5", v / 32, 7, "lo bits 7:5 frozen");
    chk("R5", int'(ovf_flag[1]), 1, "flag1 on 13-bit wrap");

    // R6: auto reload
    cur_req = "R6";
    wr(3'd0, 8'h00); wr(3'd1, 8'h02); wr(3'd3, 8'hF0); wr(3'd2, 8'hFE); wr(3'd0, 8'h10);
    idle(60);
    rd(3'd2, v); chk("R6", int'(v >= 8'hF0 && v <= 8'hF4), 1, "lo reloaded from hi");
    chk("R6", int'(ovf_flag[0]), 1, "flag0 on reload");

    // R7: split mode
    cur_req = "R7";
    wr(3'd0, 8'h00); wr(3'd1, 8'h13);
    wr(3'd2, 8'hFE); wr(3'd3, 8'h00); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    wr(3'd0, 8'h50);
    idle(60);
    chk("R7", int'(ovf_flag[0]), 1, "split lo sets flag0");
    chk("R7", int'(ovf_flag[1]), 0, "ch1 overflow kept off flag1");
    wr(3'd0, 8'h40); wr(3'd3, 8'hFE);
    idle(60);
    chk("R7", int'(ovf_flag[1]), 1, "split hi sets flag1");
    wr(3'd1, 8'h33); wr(3'd4, 8'h55);
    idle(60);
    rd(3'd4, v); chk("R7", v, 8'h55, "ch1 holds in mode 3");

    // R8: external falling edges
    cur_req = "R8";
    wr(3'd0, 8'h00); wr(3'd1, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h10);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); cnt_in[0] = 1'b0; @(negedge clk);
      @(negedge clk); cnt_in[0] = 1'b1; @(negedge clk);
    end
    idle(6);
    rd(3'd2, v); chk("R8", v, 5, "edges counted");

    // R9: gating
    cur_req = "R9";
    wr(3'd0, 8'h00); wr(3'd1, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h10);
    idle(60);
    rd(3'd2, v); chk("R9", v, 0, "gate low blocks count");
    gate_in[0] = 1'b1; idle(60);
    rd(3'd2, v); chk("R9", int'(v >= 4 && v <= 6), 1, "gate high counts");
    gate_in[0] = 1'b0; idle(5);
    rd(3'd2, v); idle(60);
    begin int v2; rd(3'd2, v2); chk("R9", v2, v, "count frozen after gate");
    end

    // R10: write collides with a counted edge
    cur_req = "R10";
    wr(3'd0, 8'h00); wr(3'd1, 8'h05); wr(3'd2, 8'h10); wr(3'd0, 8'h10);
    @(negedge clk); cnt_in[0] = 1'b0;
    @(negedge clk);
    wr(3'd2, 8'h77);
    cnt_in[0] = 1'b1; idle(6);
    rd(3'd2, v); chk("R10", v, 8'h77, "count write beats edge");
    wr(3'd1, 8'h06); wr(3'd2, 8'hFF); wr(3'd0, 8'h10);
    @(negedge clk); cnt_in[0] = 1'b0;
    @(negedge clk);
    wr(3'd0, 8'h10);
    cnt_in[0] = 1'b1; idle(6);
    chk("R10", int'(ovf_flag[0]), 0, "ctrl write beats flag set");
    rd(3'd2, v); chk("R10", v, 8'h00, "reload from hi after overflow");

    idle(10);
    finish_up();
  end
endmodule